// File: doc/BRIEF.md
# Secure-Filtered Interrupt Distributor Register Bank

This block is the byte-wide register bank of a small interrupt distributor. For every interrupt it stores an enable bit, a pending bit, an active bit, a group bit and a two-bit trigger configuration. Software reaches this state through a simple register bus that uses one-cycle read and write strobes. The address space is split into windows of 16 bytes. Each window is a set-enable, clear-enable, set-pending, clear-pending, active, group or configuration view of the same state.

Every access carries a secure attribute. When the `SEC_EXT` parameter is non-zero, an interrupt whose group bit is 0 is protected. A non-secure access sees that interrupt's bits as zero, and its writes to them have no effect. Other bits in the same byte are still read and written normally, so the filtering is done per bit and not per register. The group window itself can only be accessed by secure accesses. When `SEC_EXT` is 0, every access is treated alike.

A small bus state machine produces the read response. In `BUS_IDLE`, a read strobe moves it to `BUS_RESP`; no strobe keeps it in `BUS_IDLE`. In `BUS_RESP`, a new read strobe keeps it in `BUS_RESP` (back-to-back reads); no strobe returns it to `BUS_IDLE`. `rd_valid` is high exactly in `BUS_RESP`.

Top module: `dist_regbank`

## Requirements
- R1: `rd_valid` is 1 in the cycle after a cycle with `rd_en` = 1 and 0 otherwise. `rdata` carries the read byte while `rd_valid` is 1 and is 0 while `rd_valid` is 0.
- R2: After reset, every enable, pending, active and group bit is 0, and every configuration bit is 0 (level-triggered).
- R3: Address 0x10+n sets enable for interrupts 8n..8n+7 (bit i is interrupt 8n+i) for each 1 bit written. Address 0x20+n clears enable in the same way. A 0 bit leaves the interrupt unchanged. Both windows read back the enable bits.
- R4: Address 0x30+n sets pending and address 0x40+n clears pending, with the same bit layout and the same rule for 0 bits as R3. Both windows read back the pending bits.
- R5: Address 0x50+n reads the active bits. A write to it replaces each accessible active bit with the written bit.
- R6: Address 0x60+m covers interrupts 4m..4m+3. Bits 2i and 2i+1 belong to interrupt 4m+i, and bit 2i+1 is its edge-trigger flag. Writes store both bits of each accessible interrupt.
- R7: A configuration write to a byte whose interrupts lie below `NUM_SGI` (0x60..0x63 by default) stores the written value ORed with 0xAA, so every edge-trigger bit in that byte becomes 1.
- R8: Address 0x00+n holds the group bits of interrupts 8n..8n+7. With `SEC_EXT` set, a non-secure read of it returns 0 and a non-secure write to it is ignored. A secure access reads and writes it normally.
- R9: With `SEC_EXT` set, a non-secure read of any enable, pending, active or configuration window returns 0 in the bits of group-0 interrupts. The bits of group-1 interrupts in the same byte are returned normally.
- R10: With `SEC_EXT` set, a non-secure write has no effect on the bits of group-0 interrupts. Bits of group-1 interrupts in the same byte are updated as R3 to R6 describe.
- R11: With `SEC_EXT` = 0, non-secure accesses behave exactly like secure accesses.
- R12: An offset outside the mapped windows reads as 0, and a write to it changes no state. This includes a window selector of 7 or more, and a byte index of NUM_IRQ/8 or more (NUM_IRQ/4 or more for configuration).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | ADDR_W | Byte offset: bits [ADDR_W-1:4] select the window, bits [3:0] select the byte |
| wdata | input | 8 | Write data |
| secure | input | 1 | 1 marks the access as secure |
| rdata | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |

## Verification
The assertions take for granted that the strobes, address, data and secure attribute are synchronous to `clk` and settle before each rising edge. They also assume that reset is held low for at least one edge before any access. The bench changes every input only on the falling edge, holds a strobe for exactly one cycle and keeps reset asserted for several cycles at the start. Two instances, one with the security option and one without, get identical stimulus. Their outputs are compared every cycle against a behavioural model that tracks each configuration separately.

// File: rtl/dist_pkg.sv
package dist_pkg;

    // Which view of the per-interrupt state an address selects
    typedef enum logic [2:0] {
        WIN_GRP  = 3'd0,
        WIN_SEN  = 3'd1,
        WIN_CEN  = 3'd2,
        WIN_SPD  = 3'd3,
        WIN_CPD  = 3'd4,
        WIN_ACT  = 3'd5,
        WIN_CFG  = 3'd6,
        WIN_NONE = 3'd7
    } win_e;

    // Read-response state machine
    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_st_e;

    // Low address bits that index a byte inside a window
    localparam int WIN_SHIFT = 4;

    // True when the access must not touch this interrupt's bits
    function automatic logic ns_blocked(logic sec_on, logic secure, logic grp_bit);
        return sec_on && !secure && !grp_bit;
    endfunction

endpackage

// File: rtl/dist_decode.sv
module dist_decode
    import dist_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int ADDR_W  = 8,
    localparam int IDX_W  = WIN_SHIFT,
    localparam int SEL_W  = ADDR_W - WIN_SHIFT,
    localparam int NB_BIT = NUM_IRQ / 8,
    localparam int NB_CFG = NUM_IRQ / 4
) (
    input  logic [ADDR_W-1:0] addr,
    output win_e              win,
    output logic [IDX_W-1:0]  idx,
    output logic              hit
);

    logic [SEL_W-1:0] sel;

    assign sel = addr[ADDR_W-1:IDX_W];
    assign idx = addr[IDX_W-1:0];

    always_comb begin
        case (int'(sel))
            0:       win = WIN_GRP;
            1:       win = WIN_SEN;
            2:       win = WIN_CEN;
            3:       win = WIN_SPD;
            4:       win = WIN_CPD;
            5:       win = WIN_ACT;
            6:       win = WIN_CFG;
            default: win = WIN_NONE;
        endcase
    end

    always_comb begin
        unique case (win)
            WIN_NONE: hit = 1'b0;
            WIN_CFG:  hit = int'(idx) < NB_CFG;
            default:  hit = int'(idx) < NB_BIT;
        endcase
    end

endmodule

// File: rtl/dist_access_mask.sv
module dist_access_mask
    import dist_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int SEC_EXT = 1,
    localparam int IDX_W  = WIN_SHIFT,
    localparam int NB_BIT = NUM_IRQ / 8,
    localparam int NB_CFG = NUM_IRQ / 4
) (
    input  logic [NUM_IRQ-1:0] grp,
    input  win_e               win,
    input  logic [IDX_W-1:0]   idx,
    input  logic               secure,
    output logic [7:0]         acc
);

    localparam logic SEC_ON = (SEC_EXT != 0);

    logic blk;

    always_comb begin
        acc = '0;
        blk = 1'b0;
        unique case (win)
            WIN_GRP: begin
                // group bits are never protected by themselves: whole byte or nothing
                acc = ns_blocked(SEC_ON, secure, 1'b0) ? 8'h00 : 8'hFF;
            end
            WIN_CFG: begin
                for (int b = 0; b < NB_CFG; b++) begin
                    if (int'(idx) == b) begin
                        for (int i = 0; i < 4; i++) begin
                            blk          = ns_blocked(SEC_ON, secure, grp[b*4+i]);
                            acc[2*i]     = !blk;
                            acc[2*i+1]   = !blk;
                        end
                    end
                end
            end
            WIN_NONE: acc = '0;
            default: begin
                for (int b = 0; b < NB_BIT; b++) begin
                    if (int'(idx) == b) begin
                        for (int i = 0; i < 8; i++) begin
                            acc[i] = !ns_blocked(SEC_ON, secure, grp[b*8+i]);
                        end
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/dist_state.sv
module dist_state
    import dist_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int NUM_SGI = 16,
    localparam int IDX_W  = WIN_SHIFT,
    localparam int NB_BIT = NUM_IRQ / 8,
    localparam int NB_CFG = NUM_IRQ / 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  win_e                 win,
    input  logic [IDX_W-1:0]     idx,
    input  logic [7:0]           wdata,
    input  logic [7:0]           acc,
    output logic [NUM_IRQ-1:0]   grp,
    output logic [NUM_IRQ-1:0]   en,
    output logic [NUM_IRQ-1:0]   pend,
    output logic [NUM_IRQ-1:0]   act,
    output logic [2*NUM_IRQ-1:0] cfg
);

    logic [NUM_IRQ-1:0]   grp_q,  grp_d;
    logic [NUM_IRQ-1:0]   en_q,   en_d;
    logic [NUM_IRQ-1:0]   pend_q, pend_d;
    logic [NUM_IRQ-1:0]   act_q,  act_d;
    logic [2*NUM_IRQ-1:0] cfg_q,  cfg_d;
    logic [7:0]           wd;

    always_comb begin
        grp_d  = grp_q;
        en_d   = en_q;
        pend_d = pend_q;
        act_d  = act_q;
        cfg_d  = cfg_q;
        wd     = wdata;
        if (we) begin
            unique case (win)
                WIN_GRP: begin
                    for (int b = 0; b < NB_BIT; b++)
                        if (int'(idx) == b)
                            for (int i = 0; i < 8; i++)
                                if (acc[i]) grp_d[b*8+i] = wdata[i];
                end
                WIN_SEN: begin
                    for (int b = 0; b < NB_BIT; b++)
                        if (int'(idx) == b)
                            for (int i = 0; i < 8; i++)
                                if (acc[i] && wdata[i]) en_d[b*8+i] = 1'b1;
                end
                WIN_CEN: begin
                    for (int b = 0; b < NB_BIT; b++)
                        if (int'(idx) == b)
                            for (int i = 0; i < 8; i++)
                                if (acc[i] && wdata[i]) en_d[b*8+i] = 1'b0;
                end
                WIN_SPD: begin
                    for (int b = 0; b < NB_BIT; b++)
                        if (int'(idx) == b)
                            for (int i = 0; i < 8; i++)
                                if (acc[i] && wdata[i]) pend_d[b*8+i] = 1'b1;
                end
                WIN_CPD: begin
                    for (int b = 0; b < NB_BIT; b++)
                        if (int'(idx) == b)
                            for (int i = 0; i < 8; i++)
                                if (acc[i] && wdata[i]) pend_d[b*8+i] = 1'b0;
                end
                WIN_ACT: begin
                    for (int b = 0; b < NB_BIT; b++)
                        if (int'(idx) == b)
                            for (int i = 0; i < 8; i++)
                                if (acc[i]) act_d[b*8+i] = wdata[i];
                end
                WIN_CFG: begin
                    for (int b = 0; b < NB_CFG; b++) begin
                        if (int'(idx) == b) begin
                            // software-generated range: edge flags always set
                            wd = (b*4 < NUM_SGI) ? (wdata | 8'hAA) : wdata;
                            for (int i = 0; i < 8; i++)
                                if (acc[i]) cfg_d[b*8+i] = wd[i];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q  <= '0;
            en_q   <= '0;
            pend_q <= '0;
            act_q  <= '0;
            cfg_q  <= '0;
        end else begin
            grp_q  <= grp_d;
            en_q   <= en_d;
            pend_q <= pend_d;
            act_q  <= act_d;
            cfg_q  <= cfg_d;
        end
    end

    assign grp  = grp_q;
    assign en   = en_q;
    assign pend = pend_q;
    assign act  = act_q;
    assign cfg  = cfg_q;

endmodule

// File: rtl/dist_regbank.sv
module dist_regbank
    import dist_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int NUM_SGI = 16,
    parameter int ADDR_W  = 8,
    parameter int SEC_EXT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              secure,
    output logic [7:0]        rdata,
    output logic              rd_valid
);

    localparam int IDX_W  = WIN_SHIFT;
    localparam int NB_BIT = NUM_IRQ / 8;
    localparam int NB_CFG = NUM_IRQ / 4;

    win_e                 win;
    logic [IDX_W-1:0]     idx;
    logic                 hit;
    logic [7:0]           acc;
    logic [NUM_IRQ-1:0]   grp_v, en_v, pend_v, act_v;
    logic [2*NUM_IRQ-1:0] cfg_v;
    logic [7:0]           raw;
    logic [7:0]           rd_byte;
    bus_st_e              state_q, state_d;
    logic [7:0]           rdata_q;

    dist_decode #(
        .NUM_IRQ (NUM_IRQ),
        .ADDR_W  (ADDR_W)
    ) u_decode (
        .addr (addr),
        .win  (win),
        .idx  (idx),
        .hit  (hit)
    );

    dist_access_mask #(
        .NUM_IRQ (NUM_IRQ),
        .SEC_EXT (SEC_EXT)
    ) u_mask (
        .grp    (grp_v),
        .win    (win),
        .idx    (idx),
        .secure (secure),
        .acc    (acc)
    );

    dist_state #(
        .NUM_IRQ (NUM_IRQ),
        .NUM_SGI (NUM_SGI)
    ) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && hit),
        .win   (win),
        .idx   (idx),
        .wdata (wdata),
        .acc   (acc),
        .grp   (grp_v),
        .en    (en_v),
        .pend  (pend_v),
        .act   (act_v),
        .cfg   (cfg_v)
    );

    // Byte selected by the address, before per-bit filtering
    always_comb begin
        raw = '0;
        unique case (win)
            WIN_GRP: begin
                for (int b = 0; b < NB_BIT; b++)
                    if (int'(idx) == b) raw = grp_v[b*8 +: 8];
            end
            WIN_SEN, WIN_CEN: begin
                for (int b = 0; b < NB_BIT; b++)
                    if (int'(idx) == b) raw = en_v[b*8 +: 8];
            end
            WIN_SPD, WIN_CPD: begin
                for (int b = 0; b < NB_BIT; b++)
                    if (int'(idx) == b) raw = pend_v[b*8 +: 8];
            end
            WIN_ACT: begin
                for (int b = 0; b < NB_BIT; b++)
                    if (int'(idx) == b) raw = act_v[b*8 +: 8];
            end
            WIN_CFG: begin
                for (int b = 0; b < NB_CFG; b++)
                    if (int'(idx) == b) raw = cfg_v[b*8 +: 8];
            end
            default: raw = '0;
        endcase
    end

    assign rd_byte = hit ? (raw & acc) : 8'h00;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = rd_en ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_en ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_byte;
        else            rdata_q <= '0;
    end

    assign rdata    = rdata_q;
    assign rd_valid = (state_q == BUS_RESP);

endmodule

// File: rtl/dist_regbank_chk.sv
module dist_regbank_chk #(
    parameter int NUM_IRQ = 32,
    parameter int NUM_SGI = 16,
    parameter int ADDR_W  = 8,
    parameter int SEC_EXT = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic                 secure,
    input logic [ADDR_W-1:0]    addr,
    input logic [7:0]           rdata,
    input logic                 rd_valid,
    input logic [NUM_IRQ-1:0]   grp,
    input logic [NUM_IRQ-1:0]   en,
    input logic [NUM_IRQ-1:0]   pend,
    input logic [NUM_IRQ-1:0]   act,
    input logic [2*NUM_IRQ-1:0] cfg
);

    localparam logic SEC_ON  = (SEC_EXT != 0);
    localparam logic SGI_CFG = (NUM_SGI >= 4);

    logic [ADDR_W-5:0] sel;
    assign sel = addr[ADDR_W-1:4];

    p_rd_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_rd_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && rdata == 8'h00));

    p_grp_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (SEC_ON && wr_en && !secure) |=> $stable(grp));

    p_grp_ns_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (SEC_ON && rd_en && !secure && int'(sel) == 0) |=> rdata == 8'h00);

    p_ns_protect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (SEC_ON && wr_en && !secure) |=>
            ((((en ^ $past(en)) | (pend ^ $past(pend)) | (act ^ $past(act)))
              & ~$past(grp)) == '0));

    p_unmapped_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(sel) > 6) |=> rdata == 8'h00);

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ($stable(en) && $stable(pend) && $stable(act)
                      && $stable(grp) && $stable(cfg)));

    p_sgi_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (SGI_CFG && wr_en && secure && addr == ADDR_W'(96)) |=>
            (cfg[1] && cfg[3] && cfg[5] && cfg[7]));

endmodule

bind dist_regbank dist_regbank_chk #(
    .NUM_IRQ (NUM_IRQ),
    .NUM_SGI (NUM_SGI),
    .ADDR_W  (ADDR_W),
    .SEC_EXT (SEC_EXT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .secure   (secure),
    .addr     (addr),
    .rdata    (rdata),
    .rd_valid (rd_valid),
    .grp      (grp_v),
    .en       (en_v),
    .pend     (pend_v),
    .act      (act_v),
    .cfg      (cfg_v)
);

// File: tb/test_dist_regbank.sv
module test_dist_regbank;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_IRQ    = 32;
    localparam int NUM_SGI    = 16;
    localparam int NB_BIT     = NUM_IRQ / 8;
    localparam int NB_CFG     = NUM_IRQ / 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       secure = 1'b0;
    logic [7:0] rdata_s, rdata_o;
    logic       rv_s, rv_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model state, index 0: security option on, index 1: off
    logic [NUM_IRQ-1:0]   m_grp [2];
    logic [NUM_IRQ-1:0]   m_en  [2];
    logic [NUM_IRQ-1:0]   m_pd  [2];
    logic [NUM_IRQ-1:0]   m_act [2];
    logic [2*NUM_IRQ-1:0] m_cfg [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    dist_regbank #(.NUM_IRQ(NUM_IRQ), .NUM_SGI(NUM_SGI), .ADDR_W(8), .SEC_EXT(1)) i_dist_regbank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .secure(secure), .rdata(rdata_s), .rd_valid(rv_s));

    dist_regbank #(.NUM_IRQ(NUM_IRQ), .NUM_SGI(NUM_SGI), .ADDR_W(8), .SEC_EXT(0)) i_dist_regbank_open (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .secure(secure), .rdata(rdata_o), .rd_valid(rv_o));

    task automatic check(bit ok, string tag, int act_v, int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    function automatic bit reach(int k, int irq, bit s);
        return (k == 1) || s || m_grp[k][irq];
    endfunction

    function automatic logic [7:0] model_read(int k, int a, bit s);
        logic [7:0] r = '0;
        int win = a / 16;
        int idx = a % 16;
        if (win == 0) begin
            if (idx < NB_BIT && ((k == 1) || s)) r = m_grp[k][idx*8 +: 8];
        end else if (win >= 1 && win <= 5) begin
            if (idx < NB_BIT)
                for (int i = 0; i < 8; i++) begin
                    int irq = idx*8 + i;
                    if (reach(k, irq, s))
                        r[i] = (win <= 2) ? m_en[k][irq] :
                               (win <= 4) ? m_pd[k][irq] : m_act[k][irq];
                end
        end else if (win == 6) begin
            if (idx < NB_CFG)
                for (int i = 0; i < 4; i++) begin
                    int irq = idx*4 + i;
                    if (reach(k, irq, s)) r[2*i +: 2] = m_cfg[k][2*irq +: 2];
                end
        end
        return r;
    endfunction

    task automatic model_write(int k, int a, logic [7:0] d, bit s);
        int win = a / 16;
        int idx = a % 16;
        logic [7:0] dd;
        if (win == 0) begin
            if (idx < NB_BIT && ((k == 1) || s)) m_grp[k][idx*8 +: 8] = d;
        end else if (win >= 1 && win <= 5) begin
            if (idx < NB_BIT)
                for (int i = 0; i < 8; i++) begin
                    int irq = idx*8 + i;
                    if (reach(k, irq, s)) begin
                        case (win)
                            1: if (d[i]) m_en[k][irq] = 1'b1;
                            2: if (d[i]) m_en[k][irq] = 1'b0;
                            3: if (d[i]) m_pd[k][irq] = 1'b1;
                            4: if (d[i]) m_pd[k][irq] = 1'b0;
                            default: m_act[k][irq] = d[i];
                        endcase
                    end
                end
        end else if (win == 6) begin
            if (idx < NB_CFG) begin
                dd = (idx*4 < NUM_SGI) ? (d | 8'hAA) : d;
                for (int i = 0; i < 4; i++) begin
                    int irq = idx*4 + i;
                    if (reach(k, irq, s)) m_cfg[k][2*irq +: 2] = dd[2*i +: 2];
                end
            end
        end
    endtask

    // One bus cycle; entered and left at a falling edge, outputs compared every cycle
    task automatic cyc(bit w, bit r, int a, int d, bit s, string tag);
        logic [7:0] e_s, e_o;
        wr_en = w; rd_en = r; addr = a[7:0]; wdata = d[7:0]; secure = s;
        e_s = r ? model_read(0, a, s) : 8'h00;
        e_o = r ? model_read(1, a, s) : 8'h00;
        @(posedge clk);
        if (w) begin
            model_write(0, a, d[7:0], s);
            model_write(1, a, d[7:0], s);
        end
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        check(rv_s == r, {"R1 valid ", tag}, rv_s, r);
        check(rv_o == r, {"R1 valid open ", tag}, rv_o, r);
        check(rdata_s == e_s, {"data ", tag}, rdata_s, e_s);
        check(rdata_o == e_o, {"R11 data open ", tag}, rdata_o, e_o);
    endtask

    task automatic rd(int a, bit s, string tag);  cyc(0, 1, a, 0, s, tag); endtask
    task automatic wr(int a, int d, bit s, string tag); cyc(1, 0, a, d, s, tag); endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_grp[k] = '0; m_en[k] = '0; m_pd[k] = '0; m_act[k] = '0; m_cfg[k] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2: everything zero after reset (secure reads see all bits)
        for (int a = 0; a < 7*16; a += 16)
            for (int b = 0; b < NB_CFG; b++) rd(a + b, 1, "R2 reset");
        cyc(0, 0, 0, 0, 0, "R1 idle");

        // R8: group window locked against non-secure access
        wr(8'h00, 8'hFF, 0, "R8 ns group write");
        rd(8'h00, 0, "R8 ns group read");
        rd(8'h00, 1, "R8 secure group read");
        wr(8'h00, 8'h0F, 1, "R8 secure group write");
        wr(8'h01, 8'hFF, 1, "R8 secure group write");
        rd(8'h00, 1, "R8 group readback");

        // R3 / R10: per-bit enable filtering
        wr(8'h10, 8'hFF, 0, "R10 ns set-enable");
        rd(8'h10, 1, "R10 enable secure view");
        rd(8'h10, 0, "R9 enable ns view");
        wr(8'h10, 8'hF0, 1, "R3 secure set-enable");
        rd(8'h10, 1, "R3 enable set");
        wr(8'h20, 8'h00, 0, "R3 zero write");
        rd(8'h20, 1, "R3 zero write no change");
        wr(8'h20, 8'hFF, 0, "R10 ns clear-enable");
        rd(8'h20, 1, "R10 clear-enable result");

        // R4: pending on a group-1 byte
        wr(8'h31, 8'h5A, 0, "R4 set-pending");
        wr(8'h41, 8'h0A, 0, "R4 clear-pending");
        rd(8'h31, 0, "R4 pending readback");
        wr(8'h30, 8'hFF, 0, "R10 ns set-pending");
        rd(8'h40, 1, "R10 pending filtered");

        // R5: active window
        wr(8'h50, 8'h33, 0, "R5 ns active");
        rd(8'h50, 1, "R5 active readback");
        wr(8'h50, 8'hC0, 1, "R5 secure active");
        rd(8'h50, 0, "R9 active ns view");
        rd(8'h50, 1, "R5 active replace");

        // R6 / R7: configuration
        wr(8'h60, 8'h00, 1, "R7 sgi edge forced");
        rd(8'h60, 1, "R7 sgi readback");
        wr(8'h64, 8'hFF, 0, "R10 ns cfg protected");
        rd(8'h64, 1, "R10 cfg unchanged");
        wr(8'h64, 8'h41, 1, "R6 cfg secure");
        rd(8'h64, 1, "R6 cfg readback");
        wr(8'h61, 8'h55, 0, "R10 ns sgi cfg protected");
        rd(8'h61, 0, "R9 cfg ns view");
        rd(8'h61, 1, "R7 cfg secure view");

        // R12: unmapped space
        wr(8'h70, 8'hFF, 1, "R12 unmapped write");
        rd(8'h70, 1, "R12 unmapped read");
        wr(8'h14, 8'hFF, 1, "R12 index beyond range");
        rd(8'h14, 1, "R12 index beyond range read");
        rd(8'h68, 1, "R12 cfg index beyond range");

        // mixed traffic, back-to-back reads included
        for (int n = 0; n < 600; n++) begin
            int a  = int'($urandom % 8) * 16 + int'($urandom % 9);
            bit w  = 1'($urandom % 2);
            bit r  = 1'($urandom % 2);
            bit s  = ($urandom % 3) == 0;
            cyc(w, r, a, int'($urandom % 256), s, "R9 R10 mixed");
        end

        // final sweep of all state through the secure view
        for (int a = 0; a < 7*16; a += 16)
            for (int b = 0; b < NB_CFG; b++) rd(a + b, 1, "R11 final sweep");
        cyc(0, 0, 0, 0, 0, "R1 idle");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule